// File: doc/BRIEF.md
# Programmable ATA PIO Cycle Timer

This block times the read and write strobes of a parallel ATA host port. A request carries the access class (data port or task-file register), the drive-select bit and the direction. The block latches these, asserts the matching strobe for a programmed active time, and then holds off for a programmed recovery time before it takes another request. Each timing value lives in one byte lane of a 16-bit register, one lane per device, so the two devices and the two access classes each get their own active/recovery pair.

A small register bank behind a simple byte-enabled write port and a combinational read port holds the timing fields, a 16-bit IORDY timeout limit, an interface enable, two per-device Ultra DMA select bits kept for the DMA engine, and a sticky timeout flag. While the device holds IORDY low at the end of the active phase, the strobe stays asserted and the timeout counter runs down. If it reaches zero, the access is ended and the flag is set.

The controller has three states. `ST_IDLE` goes to `ST_STROBE` on a request while the interface is enabled. `ST_STROBE` goes to `ST_RECOVER` when its count is spent and IORDY is high, or when the timeout runs out. `ST_RECOVER` goes back to `ST_IDLE` when the recovery count is spent.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset, the control register (address 0) reads 0x0000, timing registers 1 to 4 read 0xFFFF, and the timeout register (address 5) reads 0xFFFF.
- R2: With a strobe field of N and IORDY high, the selected strobe is high for exactly N+1 clocks.
- R3: With a recovery field of R, busy stays high for exactly N+R+2 clocks, from the first strobe clock to the end of recovery. A strobe is never high while busy is low.
- R4: A data-port access uses addresses 1 (strobe) and 2 (recovery). A task-file access uses addresses 3 (strobe) and 4 (recovery). Bits [7:0] apply to device 0 and bits [15:8] to device 1. A write access drives wr_strobe, a read access drives rd_strobe, and the two are never high together.
- R5: A write updates only the byte lanes whose cfg_be bit is set (bit 0 selects [7:0], bit 1 selects [15:8]). The other lane keeps its value.
- R6: Control bit 15 is the interface enable. While it is 0, requests start no access and busy stays low.
- R7: If IORDY is low when the strobe count is spent, the strobe stays high until the first clock at which IORDY is sampled high.
- R8: With timeout limit T and IORDY held low, the strobe lasts N+1+T clocks. The sticky flag (control bit 8 and timeout_flag) then sets.
- R9: Writing 1 to control bit 8 with cfg_be[1] set clears the flag. Writing 0 to that bit leaves the flag unchanged.
- R10: A timing register written during an access does not change that access. It applies from the next access onward.
- R11: Requests are taken only in the idle state. A request held high through an access is taken after exactly one idle clock.
- R12: Control bits [1:0] are per-device Ultra DMA selects. They read back as written and do not alter PIO strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index for write and read |
| cfg_be | input | 2 | Byte-lane write enables |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| acc_req | input | 1 | Access request |
| acc_data | input | 1 | 1 = data port, 0 = task-file register |
| acc_dev | input | 1 | Drive-select bit |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| iordy | input | 1 | Device ready; low stretches the strobe |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| busy | output | 1 | High from first strobe clock to end of recovery |
| timeout_flag | output | 1 | Sticky IORDY timeout flag |

## Verification
The bench measures strobe and busy widths in whole clocks for random lane, class and device choices, including zero-valued fields, where an off-by-one counter would give 0 or 2 clocks. It releases IORDY at a chosen point inside the stall and also holds it low for a full timeout. A design that ignored IORDY would end the strobe early, and one that counted the timeout wrongly would miss the exact N+1+T width or leave the flag clear.

It rewrites the active strobe register in the middle of an access, which exposes a design that reloads live values. It also holds the request high across an access, which exposes a design that skips or doubles the idle clock. Single-lane writes and flag writes of 0 expose byte-enable and clear-bit decoding errors.

// File: rtl/pio_tmr_pkg.sv
package pio_tmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RECOVER = 2'd2
    } tmr_state_e;

    // register indices; classes 0..3 map to indices 1..4
    localparam int unsigned IDX_CTRL = 0;
    localparam int unsigned IDX_TMO  = 5;
    localparam int unsigned NUM_CLS  = 4;
    localparam int unsigned NUM_DEV  = 2;

    // control bit positions
    localparam int unsigned CTL_EN   = 15;
    localparam int unsigned CTL_FLAG = 8;
endpackage

// File: rtl/pio_tmr_regs.sv
module pio_tmr_regs
    import pio_tmr_pkg::*;
#(
    parameter int unsigned FW = 8,
    parameter int unsigned AW = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   we,
    input  logic [AW-1:0]                          addr,
    input  logic [NUM_DEV-1:0]                     be,
    input  logic [NUM_DEV*FW-1:0]                  wdata,
    output logic [NUM_DEV*FW-1:0]                  rdata,
    input  logic                                   tmo_set,
    output logic                                   en,
    output logic [NUM_DEV-1:0]                     udma,
    output logic                                   tmo_flag,
    output logic [NUM_CLS-1:0][NUM_DEV-1:0][FW-1:0] tim,
    output logic [NUM_DEV*FW-1:0]                  tmo_limit
);
    localparam int unsigned DW = NUM_DEV * FW;

    logic [DW-1:0] tmo_q;
    logic          en_q;
    logic [NUM_DEV-1:0] udma_q;
    logic          flag_q;

    for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
        for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
            logic [FW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '1;
                end else if (we && be[d] && addr == AW'(k + 1)) begin
                    q <= wdata[d*FW +: FW];
                end
            end
            assign tim[k][d] = q;
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_tmo
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tmo_q[d*FW +: FW] <= '1;
            end else if (we && be[d] && addr == AW'(IDX_TMO)) begin
                tmo_q[d*FW +: FW] <= wdata[d*FW +: FW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            udma_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (we && addr == AW'(IDX_CTRL)) begin
                if (be[1]) en_q   <= wdata[CTL_EN];
                if (be[0]) udma_q <= wdata[NUM_DEV-1:0];
            end
            if (tmo_set) begin
                flag_q <= 1'b1;
            end else if (we && addr == AW'(IDX_CTRL) && be[1] && wdata[CTL_FLAG]) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(IDX_CTRL)) begin
            rdata[CTL_EN]        = en_q;
            rdata[CTL_FLAG]      = flag_q;
            rdata[NUM_DEV-1:0]   = udma_q;
        end else if (addr == AW'(IDX_TMO)) begin
            rdata = tmo_q;
        end else begin
            for (int k = 0; k < NUM_CLS; k++) begin
                if (addr == AW'(k + 1)) rdata = tim[k];
            end
        end
    end

    assign en        = en_q;
    assign udma      = udma_q;
    assign tmo_flag  = flag_q;
    assign tmo_limit = tmo_q;
endmodule

// File: rtl/pio_tmr_fsm.sv
module pio_tmr_fsm
    import pio_tmr_pkg::*;
#(
    parameter int unsigned FW = 8,
    parameter int unsigned TW = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   en,
    input  logic                                   req,
    input  logic                                   req_data,
    input  logic                                   req_dev,
    input  logic                                   req_wr,
    input  logic                                   iordy,
    input  logic [NUM_CLS-1:0][NUM_DEV-1:0][FW-1:0] tim,
    input  logic [TW-1:0]                          tmo_limit,
    output logic                                   rd_stb,
    output logic                                   wr_stb,
    output logic                                   busy,
    output logic                                   tmo_hit
);
    tmr_state_e    state_q;
    logic [FW-1:0] cnt_q;
    logic [FW-1:0] rcv_q;
    logic [TW-1:0] tmo_q;
    logic          wr_q;

    logic [1:0]    stb_idx;
    logic [1:0]    rcv_idx;
    logic          cnt_zero;

    assign stb_idx  = req_data ? 2'd0 : 2'd2;
    assign rcv_idx  = req_data ? 2'd1 : 2'd3;
    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rcv_q   <= '0;
            tmo_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req && en) begin
                        state_q <= ST_STROBE;
                        cnt_q   <= tim[stb_idx][req_dev];
                        rcv_q   <= tim[rcv_idx][req_dev];
                        tmo_q   <= tmo_limit;
                        wr_q    <= req_wr;
                    end
                end
                ST_STROBE: begin
                    if (!cnt_zero) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (iordy || tmo_q == '0) begin
                        state_q <= ST_RECOVER;
                        cnt_q   <= rcv_q;
                    end else begin
                        tmo_q <= tmo_q - 1'b1;
                    end
                end
                ST_RECOVER: begin
                    if (cnt_zero) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_stb  = (state_q == ST_STROBE) && !wr_q;
        wr_stb  = (state_q == ST_STROBE) &&  wr_q;
        busy    = (state_q != ST_IDLE);
        tmo_hit = (state_q == ST_STROBE) && cnt_zero && !iordy && (tmo_q == '0);
    end
endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
    import pio_tmr_pkg::*;
#(
    parameter int unsigned FW = 8,
    parameter int unsigned AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [1:0]        cfg_be,
    input  logic [2*FW-1:0]   cfg_wdata,
    output logic [2*FW-1:0]   cfg_rdata,
    input  logic              acc_req,
    input  logic              acc_data,
    input  logic              acc_dev,
    input  logic              acc_wr,
    input  logic              iordy,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              busy,
    output logic              timeout_flag
);
    localparam int unsigned TW = NUM_DEV * FW;

    logic                                   en_w;
    logic [NUM_DEV-1:0]                     udma_w;
    logic                                   tmo_hit_w;
    logic [NUM_CLS-1:0][NUM_DEV-1:0][FW-1:0] tim_w;
    logic [TW-1:0]                          tmo_limit_w;

    pio_tmr_regs #(.FW(FW), .AW(AW)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .be        (cfg_be),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .tmo_set   (tmo_hit_w),
        .en        (en_w),
        .udma      (udma_w),
        .tmo_flag  (timeout_flag),
        .tim       (tim_w),
        .tmo_limit (tmo_limit_w)
    );

    pio_tmr_fsm #(.FW(FW), .TW(TW)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_w),
        .req       (acc_req),
        .req_data  (acc_data),
        .req_dev   (acc_dev),
        .req_wr    (acc_wr),
        .iordy     (iordy),
        .tim       (tim_w),
        .tmo_limit (tmo_limit_w),
        .rd_stb    (rd_strobe),
        .wr_stb    (wr_strobe),
        .busy      (busy),
        .tmo_hit   (tmo_hit_w)
    );
endmodule

// File: rtl/pio_cycle_timer_chk.sv
module pio_cycle_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_strobe,
    input logic wr_strobe,
    input logic busy,
    input logic iordy,
    input logic acc_req,
    input logic en,
    input logic timeout_flag
);
    // R4
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));

    // R3
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe || wr_strobe) |-> busy);

    // R6
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(acc_req) && $past(en)));

    // R8
    timeout_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_strobe || wr_strobe) && !$past(iordy)) |-> timeout_flag);

    // R11
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rd_strobe || wr_strobe));
endmodule

bind pio_cycle_timer pio_cycle_timer_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_strobe    (rd_strobe),
    .wr_strobe    (wr_strobe),
    .busy         (busy),
    .iordy        (iordy),
    .acc_req      (acc_req),
    .en           (en_w),
    .timeout_flag (timeout_flag)
);

// File: tb/test_pio_cycle_timer.sv
module test_pio_cycle_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [1:0]  cfg_be = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        acc_req = 1'b0;
    logic        acc_data = 1'b0;
    logic        acc_dev = 1'b0;
    logic        acc_wr = 1'b0;
    logic        iordy = 1'b1;
    logic        rd_strobe, wr_strobe, busy, timeout_flag;

    int checks = 0;
    int errors = 0;
    logic [15:0] img [6];

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_cycle_timer i_pio_cycle_timer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_req(acc_req), .acc_data(acc_data), .acc_dev(acc_dev),
        .acc_wr(acc_wr), .iordy(iordy), .rd_strobe(rd_strobe),
        .wr_strobe(wr_strobe), .busy(busy), .timeout_flag(timeout_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] be);
        logic [15:0] r = old;
        if (be[0]) r[7:0]  = nw[7:0];
        if (be[1]) r[15:8] = nw[15:8];
        return r;
    endfunction

    function automatic int field(input int a, input bit dev);
        return dev ? int'(img[a][15:8]) : int'(img[a][7:0]);
    endfunction

    function automatic int exp_strobe(input int n, input int rel, input int t);
        if (rel < 0) return n + 1;
        if (rel == 0) return n + 1 + t;
        if (rel < n + 1) return n + 1;
        if (rel > n + 1 + t) return n + 1 + t;
        return rel;
    endfunction

    task automatic cfg_write(input int a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = '0;
        if (a >= 1 && a <= 5) img[a] = merge(img[a], d, be);
    endtask

    task automatic cfg_read(input int a, output logic [15:0] r);
        @(negedge clk);
        cfg_addr = 3'(a);
        #1 r = cfg_rdata;
    endtask

    // rel: -1 keep iordy high, 0 keep low, >0 release when strobe count reaches rel
    task automatic do_access(input bit data, input bit dev, input bit wr, input int rel,
                             input int poke, output int sw, output int bw, output bit bad);
        int guard = 0;
        sw = 0; bw = 0; bad = 1'b0;
        @(negedge clk);
        acc_data = data; acc_dev = dev; acc_wr = wr; acc_req = 1'b1;
        iordy = (rel < 0);
        @(negedge clk);
        acc_req = 1'b0;
        acc_dev = ~dev; acc_data = ~data;
        while (busy && guard < 70000) begin
            if (rd_strobe || wr_strobe) begin
                sw++;
                if (wr ? rd_strobe : wr_strobe) bad = 1'b1;
            end
            bw++;
            if (rel > 0 && sw == rel) iordy = 1'b1;
            if (poke >= 0 && sw == 1) begin
                cfg_we = 1'b1; cfg_addr = 3'd1; cfg_be = 2'b11; cfg_wdata = 16'(poke);
            end
            if (poke >= 0 && sw == 2) begin
                cfg_we = 1'b0; cfg_be = '0;
                img[1] = 16'(poke);
            end
            @(negedge clk);
            guard++;
        end
        iordy = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] r;
        int sw, bw, n, rv, a_s, a_r;
        bit bad;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int i = 1; i <= 5; i++) img[i] = 16'hFFFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        cfg_read(0, r); check("R1 ctrl", int'(r), 0);
        for (int a = 1; a <= 5; a++) begin
            cfg_read(a, r); check("R1 field", int'(r), 16'hFFFF);
        end

        // R6 disabled: request ignored
        cfg_write(1, 16'h0101, 2'b11); cfg_write(2, 16'h0101, 2'b11);
        @(negedge clk); acc_req = 1'b1; @(negedge clk); acc_req = 1'b0;
        check("R6 busy while disabled", int'(busy), 0);
        repeat (2) @(negedge clk);
        check("R6 strobe while disabled", int'(rd_strobe | wr_strobe), 0);

        cfg_write(0, 16'h8000, 2'b10);
        cfg_read(0, r); check("R6 enable readback", int'(r), 16'h8000);

        // R5 lane write leaves other lane
        cfg_write(3, 16'h0203, 2'b11);
        cfg_write(3, 16'h0705, 2'b01);
        cfg_read(3, r); check("R5 low lane only", int'(r), 16'h0205);
        cfg_write(3, 16'h0900, 2'b10);
        cfg_read(3, r); check("R5 high lane only", int'(r), 16'h0905);

        // R12 udma bits read back, no timing effect
        cfg_write(0, 16'h0003, 2'b01);
        cfg_read(0, r); check("R12 udma readback", int'(r), 16'h8003);
        cfg_write(1, 16'h0302, 2'b11); cfg_write(2, 16'h0104, 2'b11);
        do_access(1'b1, 1'b0, 1'b0, -1, -1, sw, bw, bad);
        check("R12 strobe unchanged", sw, 3);
        check("R12 busy unchanged", bw, 8);
        cfg_write(0, 16'h0000, 2'b01);

        // R2 R3 R4 random class/device/direction with single-lane programming
        for (int it = 0; it < 40; it++) begin
            bit dd, dv, w;
            dd = 1'($urandom); dv = 1'($urandom); w = 1'($urandom);
            a_s = dd ? 1 : 3; a_r = dd ? 2 : 4;
            n = int'($urandom % 7); rv = int'($urandom % 7);
            cfg_write(a_s, dv ? 16'(n << 8) : 16'(n), dv ? 2'b10 : 2'b01);
            cfg_write(a_r, dv ? 16'(rv << 8) : 16'(rv), dv ? 2'b10 : 2'b01);
            do_access(dd, dv, w, -1, -1, sw, bw, bad);
            check("R2 strobe width", sw, field(a_s, dv) + 1);
            check("R3 busy span", bw, field(a_s, dv) + field(a_r, dv) + 2);
            check("R4 strobe line", int'(bad), 0);
        end

        // R7 iordy stall released inside window
        cfg_write(1, 16'h0002, 2'b01); cfg_write(2, 16'h0001, 2'b01);
        cfg_write(5, 16'd10, 2'b11);
        do_access(1'b1, 1'b0, 1'b1, 6, -1, sw, bw, bad);
        check("R7 stretched strobe", sw, exp_strobe(2, 6, 10));
        check("R7 no flag", int'(timeout_flag), 0);

        // R8 timeout
        cfg_write(5, 16'd4, 2'b11);
        do_access(1'b1, 1'b0, 1'b0, 0, -1, sw, bw, bad);
        check("R8 timeout width", sw, exp_strobe(2, 0, 4));
        check("R8 flag set", int'(timeout_flag), 1);

        // R9 write 0 keeps, write 1 clears
        cfg_write(0, 16'h8000, 2'b10);
        check("R9 flag kept", int'(timeout_flag), 1);
        cfg_write(0, 16'h8100, 2'b10);
        check("R9 flag cleared", int'(timeout_flag), 0);
        cfg_read(0, r); check("R9 ctrl readback", int'(r), 16'h8000);

        // R10 mid-access rewrite applies next time
        cfg_write(1, 16'h0404, 2'b11);
        do_access(1'b1, 1'b1, 1'b0, -1, 16'h0101, sw, bw, bad);
        check("R10 current access", sw, 5);
        do_access(1'b1, 1'b1, 1'b0, -1, -1, sw, bw, bad);
        check("R10 next access", sw, 2);

        // R11 held request: exactly one idle clock between accesses
        @(negedge clk);
        acc_data = 1'b1; acc_dev = 1'b0; acc_wr = 1'b1; acc_req = 1'b1;
        @(negedge clk);
        check("R11 started", int'(busy), 1);
        while (busy) @(negedge clk);
        check("R11 idle clock", int'(busy), 0);
        @(negedge clk);
        check("R11 restart after one idle", int'(busy), 1);
        acc_req = 1'b0;
        while (busy) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule